// File: doc/BRIEF.md
# JTAG Debug Register Access Chain

This block is a serial data chain that lets a JTAG debugger read and write a bank of 32 debug registers, each 32 bits wide. The TAP controller sits outside the block. It supplies one-hot state strobes for capture, shift and update, a chain-select qualifier, TCK (used as `clk`) and TDI. The block returns TDO. Each scanned word is 38 bits long and holds three things: a write flag, a register address and a data field.

The access is committed only when the TAP passes through update. A write stores the data field into the addressed register. A read only records the address. On the next capture the register's content is loaded into the data field, so the following scan shifts it out. The full register bank is also exposed as a flat vector, which the debug comparators (outside this block) consume.

Top module: `dbg_scan_chain`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, all debug registers and the 38-bit chain clear to zero, so `tdo` reads 0.
- R2: With `chain_sel` high and `st_shift` high, each clock moves the chain one place toward bit 0. `tdi` enters bit 37 and `tdo` always shows bit 0, so the least significant bit leaves first.
- R3: Field layout of the chain: bits 31:0 are data, bits 36:32 are the register address, and bit 37 is the direction flag (1 = write, 0 = read).
- R4: At an update edge with bit 37 = 1, the addressed register takes bits 31:0. It shows in `regs_flat[addr*32 +: 32]` after that edge.
- R5: At an update edge with bit 37 = 0, no register changes and the address is kept for the next capture.
- R6: The first capture after a read request loads chain bits 31:0 with the addressed register's content at that capture edge, and leaves bits 37:32 unchanged.
- R7: A capture with no read pending leaves the whole chain unchanged. A read request is served by one capture only.
- R8: While `chain_sel` is low, the capture, shift and update strobes have no effect on the chain or on the registers.
- R9: In a cycle with no strobe asserted, the chain and the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst | input | 1 | Synchronous active-high test reset |
| chain_sel | input | 1 | This chain is selected by the instruction register |
| st_capture | input | 1 | TAP is in the capture-DR state |
| st_shift | input | 1 | TAP is in the shift-DR state |
| st_update | input | 1 | TAP is in the update-DR state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| regs_flat | output | 1024 | All debug registers; register n at bits n*32 +: 32 |

## Verification
The bench checks that a capture reads the register before the update of the same scan can write it. A design that swapped the two would return the new value instead of the old one. It checks that a capture with no read pending leaves the previous scanned word intact, and that a second capture does not reload the data. A design that captured on every pass would corrupt the returned word or clear it. The bench also runs a complete capture, shift and update sequence with the chain deselected, then confirms that neither the chain nor the bank moved; a missing qualifier would overwrite a register. The vector table uses addresses 0 and 31 and writes one address twice, to expose address decoding off by one bit and ordering faults where the last write should win.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

    localparam int DFLT_DATA_W = 32;
    localparam int DFLT_ADDR_W = 5;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } tap_op_e;

    // Strobes are qualified by the chain select; capture wins if several are set.
    function automatic tap_op_e decode_op(input logic sel, input logic cap,
                                          input logic sh, input logic up);
        if (!sel)      return OP_IDLE;
        else if (cap)  return OP_CAPTURE;
        else if (sh)   return OP_SHIFT;
        else if (up)   return OP_UPDATE;
        else           return OP_IDLE;
    endfunction

endpackage

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
    import dbg_chain_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W,
    localparam int CHAIN_W = DATA_W + ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_op_e            op,
    input  logic [CHAIN_W-1:0] word,
    output logic               we,
    output logic [ADDR_W-1:0]  waddr,
    output logic [DATA_W-1:0]  wdata,
    output logic               cap_load,
    output logic [ADDR_W-1:0]  raddr
);
    localparam int FLAG_BIT = CHAIN_W - 1;

    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              is_write;
    logic [ADDR_W-1:0] word_addr;

    assign is_write  = word[FLAG_BIT];
    assign word_addr = word[DATA_W +: ADDR_W];

    always_comb begin
        we       = (op == OP_UPDATE) && is_write;
        waddr    = word_addr;
        wdata    = word[DATA_W-1:0];
        cap_load = (op == OP_CAPTURE) && rd_pend;
        raddr    = rd_addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            case (op)
                OP_UPDATE: begin
                    if (!is_write) begin
                        rd_pend   <= 1'b1;
                        rd_addr_q <= word_addr;
                    end
                end
                OP_CAPTURE: rd_pend <= 1'b0;
                default: ;
            endcase
        end
    end

    // R5: a read request leaves a pending read on the recorded address
    p_read_pend_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UPDATE && !word[FLAG_BIT]) |=> (rd_pend && raddr == $past(word[DATA_W +: ADDR_W])));

    // R7: one capture consumes the pending read
    p_single_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE) |=> !cap_load);

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_chain_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      raddr,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && waddr == ADDR_W'(g))
                mem[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
    end

    assign rdata = mem[raddr];

    // R4: a write lands in the addressed register
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_flat[$past(waddr)*DATA_W +: DATA_W] == $past(wdata)));

    // R5: without a write strobe the bank holds
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg
    import dbg_chain_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W,
    localparam int CHAIN_W = DATA_W + ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_op_e            op,
    input  logic               cap_load,
    input  logic [DATA_W-1:0]  cap_data,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] word,
    output logic               tdo
);
    logic [CHAIN_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            case (op)
                OP_SHIFT:   sr <= {tdi, sr[CHAIN_W-1:1]};
                OP_CAPTURE: if (cap_load) sr[DATA_W-1:0] <= cap_data;
                default: ;
            endcase
        end
    end

    assign word = sr;
    assign tdo  = sr[0];

    // R2: shift moves toward bit 0 and takes tdi at the top
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (sr[CHAIN_W-2:0] == $past(sr[CHAIN_W-1:1]) && sr[CHAIN_W-1] == $past(tdi)));

    // R6: capture keeps the address and flag fields
    p_capture_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE) |=> $stable(sr[CHAIN_W-1:DATA_W]));

    // R9: no shift or loading capture, no change
    p_chain_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SHIFT && !cap_load) |=> $stable(sr));

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbg_chain_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int ADDR_W = DFLT_ADDR_W,
    localparam int NREG = 1 << ADDR_W,
    localparam int CHAIN_W = DATA_W + ADDR_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   chain_sel,
    input  logic                   st_capture,
    input  logic                   st_shift,
    input  logic                   st_update,
    input  logic                   tdi,
    output logic                   tdo,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    tap_op_e            op;
    logic [CHAIN_W-1:0] word;
    logic               we;
    logic [ADDR_W-1:0]  waddr;
    logic [DATA_W-1:0]  wdata;
    logic               cap_load;
    logic [ADDR_W-1:0]  raddr;
    logic [DATA_W-1:0]  rdata;

    assign op = decode_op(chain_sel, st_capture, st_shift, st_update);

    dbg_shift_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chain (
        .clk(clk), .rst(rst), .op(op), .cap_load(cap_load),
        .cap_data(rdata), .tdi(tdi), .word(word), .tdo(tdo)
    );

    dbg_access_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk), .rst(rst), .op(op), .word(word), .we(we),
        .waddr(waddr), .wdata(wdata), .cap_load(cap_load), .raddr(raddr)
    );

    dbg_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .regs_flat(regs_flat)
    );

    // R2: the TAP gives one state strobe at a time
    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_capture, st_shift, st_update}));

    // R8: a deselected chain neither moves nor writes
    p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        !chain_sel |=> ($stable(word) && $stable(regs_flat)));

    // R1: reset leaves the chain empty
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (word == '0));

endmodule

// File: tb/test_dbg_scan_chain.sv
module test_dbg_scan_chain;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NR = 1 << AW;
    localparam int CW = DW + AW + 1;
    localparam int NVEC = 8;

    // {address, data}
    localparam logic [AW+DW-1:0] VEC [NVEC] = '{
        {5'd0,  32'hDEAD_BEEF},
        {5'd31, 32'hA5A5_5A5A},
        {5'd1,  32'h0000_0001},
        {5'd30, 32'h8000_0000},
        {5'd7,  32'hFFFF_FFFF},
        {5'd16, 32'h1234_5678},
        {5'd2,  32'h0F0F_F0F0},
        {5'd31, 32'hCAFE_F00D}
    };

    logic clk = 1'b0;
    logic rst, chain_sel, st_capture, st_shift, st_update, tdi;
    logic tdo;
    logic [NR*DW-1:0] regs_flat;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] bmodel [NR];

    always #2.5 clk = ~clk;

    dbg_scan_chain i_dbg_scan_chain (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .st_capture(st_capture),
        .st_shift(st_shift), .st_update(st_update), .tdi(tdi), .tdo(tdo),
        .regs_flat(regs_flat)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] mkw(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        return {wr, a, d};
    endfunction

    // capture, 38 shifts, update; dout collects tdo before each shift edge
    task automatic scan(input logic [CW-1:0] din, output logic [CW-1:0] dout, input logic s);
        @(negedge clk);
        chain_sel = s; st_capture = 1'b1;
        @(posedge clk); @(negedge clk);
        st_capture = 1'b0; st_shift = 1'b1;
        for (int i = 0; i < CW; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            @(posedge clk); @(negedge clk);
        end
        st_shift = 1'b0; st_update = 1'b1;
        @(posedge clk); @(negedge clk);
        st_update = 1'b0; chain_sel = 1'b1;
        if (s && din[CW-1]) bmodel[din[DW +: AW]] = din[DW-1:0];
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NR; k++) bmodel[k] = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] o, last;
        logic [NR*DW-1:0] snap;
        logic [AW-1:0] pa;
        rst = 1'b0; chain_sel = 1'b1; st_capture = 1'b0; st_shift = 1'b0;
        st_update = 1'b0; tdi = 1'b0;

        do_reset();
        chk("R1 regs after reset", 64'(regs_flat == '0), 64'd1);
        chk("R1 tdo after reset", 64'(tdo), 64'd0);
        scan(mkw(1'b0, 5'd3, 32'h0), o, 1'b1);
        chk("R1 chain after reset", 64'(o), 64'd0);

        // vector table: write every entry, last write wins
        for (int v = 0; v < NVEC; v++) begin
            scan({1'b1, VEC[v]}, o, 1'b1);
            chk("R4 R3 write lands", 64'(regs_flat[VEC[v][DW +: AW]*DW +: DW]), 64'(VEC[v][DW-1:0]));
        end
        // read back in a chain of scans; each returns the previous request
        scan(mkw(1'b0, VEC[0][DW +: AW], 32'h0), o, 1'b1);
        chk("R7 write word held", 64'(o), 64'({1'b1, VEC[NVEC-1]}));
        for (int v = 1; v <= NVEC; v++) begin
            pa = VEC[v-1][DW +: AW];
            scan(mkw(1'b0, (v < NVEC) ? VEC[v % NVEC][DW +: AW] : 5'd0, 32'h0), o, 1'b1);
            chk("R6 R2 read data", 64'(o[DW-1:0]), 64'(bmodel[pa]));
            chk("R6 upper kept", 64'(o[CW-1:DW]), 64'({1'b0, pa}));
        end
        chk("R5 reads left bank", 64'(regs_flat[31*DW +: DW]), 64'h0000_0000_CAFE_F00D);

        // capture happens before the same scan's update: old value returned
        scan(mkw(1'b0, 5'd7, 32'h0), o, 1'b1);
        scan(mkw(1'b1, 5'd7, 32'h1111_2222), o, 1'b1);
        chk("R6 old value at capture", 64'(o[DW-1:0]), 64'h0000_0000_FFFF_FFFF);
        chk("R4 new value after update", 64'(regs_flat[7*DW +: DW]), 64'h0000_0000_1111_2222);
        // no read pending now: the chain must still hold the write word
        scan(mkw(1'b1, 5'd9, 32'h9999_0000), o, 1'b1);
        chk("R7 no reload", 64'(o), 64'(mkw(1'b1, 5'd7, 32'h1111_2222)));
        last = mkw(1'b1, 5'd9, 32'h9999_0000);

        // deselected full scan must change nothing
        snap = regs_flat;
        scan(mkw(1'b1, 5'd9, 32'h7777_7777), o, 1'b0);
        chk("R8 bank unchanged", 64'(regs_flat == snap), 64'd1);
        scan(mkw(1'b0, 5'd9, 32'h0), o, 1'b1);
        chk("R8 chain unchanged", 64'(o), 64'(last));
        chk("R8 reg9 unchanged", 64'(regs_flat[9*DW +: DW]), 64'h0000_0000_9999_0000);

        // a read served once: capture-only pass, then a scan must not reload
        @(negedge clk); st_capture = 1'b1;
        @(posedge clk); @(negedge clk); st_capture = 1'b0;
        chk("R6 tdo shows read bit0", 64'(tdo), 64'd0);
        scan(mkw(1'b1, 5'd9, 32'h0000_00AA), o, 1'b1);
        chk("R7 single capture", 64'(o), 64'(mkw(1'b0, 5'd9, 32'h9999_0000)));

        // idle: nothing moves
        snap = regs_flat;
        repeat (6) @(negedge clk);
        chk("R9 bank idle", 64'(regs_flat == snap), 64'd1);
        scan(mkw(1'b0, 5'd0, 32'h0), o, 1'b1);
        chk("R9 chain idle", 64'(o), 64'(mkw(1'b1, 5'd9, 32'h0000_00AA)));

        // reset in the middle of use
        do_reset();
        chk("R1 bank cleared", 64'(regs_flat == '0), 64'd1);
        scan(mkw(1'b0, 5'd0, 32'h0), o, 1'b1);
        chk("R1 chain cleared", 64'(o), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule